// File: doc/BRIEF.md
# Dual-Channel Interrupt Status Aggregator

This block keeps the eight-bit interrupt status word of a two-channel serial controller and drives an active-low interrupt request toward the processor. Each channel reports three events: transmitter ready, receiver ready or FIFO full, and change in break. A counter/timer ready event and an input-port change event complete the word. An event sets its bit, and the bit stays set until its own processor action clears it.

No bit clears on an interrupt acknowledge, and no bit clears through a generic write. A transmit bit clears on a write into that channel's transmit holding register. A receive bit clears on a read of that channel's receive buffer, but only when the read leaves no data behind. A break-change bit clears on that channel's reset-break-change command. The timer bit clears on a stop-counter command, and the input-change bit clears on a read of the input change register. An eight-bit mask decides which set bits raise the interrupt.

Top module: `irq_status_hub`

## Requirements
- R1: A synchronous active-high reset clears the status word and the mask to zero, and `irq_n` reads 1 afterwards.
- R2: Each event sets its status bit on the following clock edge, and the bit stays set while no clearing action for it occurs. Bit positions: 0 channel 0 transmit ready, 1 channel 0 receive ready, 2 channel 0 break change, 3 timer ready, 4 channel 1 transmit ready, 5 channel 1 receive ready, 6 channel 1 break change, 7 input change.
- R3: A transmit holding register write for channel c clears bit 4c on the next edge.
- R4: A receive buffer read for channel c clears bit 4c+1 on the next edge when `acc_rx_more[c]` is 0. When it is 1, the bit stays set.
- R5: A reset-break-change command for channel c clears bit 4c+2 on the next edge. No other action clears that bit.
- R6: A stop-counter command clears bit 3 on the next edge.
- R7: A read of the input change register clears bit 7 on the next edge.
- R8: An interrupt acknowledge (`intack`) clears no status bit.
- R9: When a set event and a clear action for the same bit fall in the same cycle, the bit is set after the edge.
- R10: `irq_n` is 0 exactly when the status word ANDed with the mask is nonzero. It follows the registered status and mask without an extra cycle.
- R11: When `mask_we` is 1, `mask_wdata` loads into the mask on the next edge. Otherwise the mask holds its value.
- R12: A clearing action for one channel leaves the other channel's bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_tx_rdy | input | 2 | Transmitter ready event, one per channel |
| evt_rx_rdy | input | 2 | Receiver ready / FIFO full event, one per channel |
| evt_brk_chg | input | 2 | Change-in-break event, one per channel |
| evt_tmr_rdy | input | 1 | Counter/timer ready event |
| evt_in_chg | input | 1 | Input-port change event |
| acc_tx_write | input | 2 | Write strobe of the transmit holding register, per channel |
| acc_rx_read | input | 2 | Read strobe of the receive buffer, per channel |
| acc_rx_more | input | 2 | Receive data still remains after this read, per channel |
| cmd_brk_ack | input | 2 | Reset-break-change command, per channel |
| cmd_tmr_stop | input | 1 | Stop-counter command |
| acc_in_chg_read | input | 1 | Read strobe of the input change register |
| intack | input | 1 | Interrupt acknowledge cycle |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write data |
| stat | output | 8 | Interrupt status word |
| mask | output | 8 | Mask register contents |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Directed cases apply each clearing action alone on a fully set word, which shows whether the action hits only its own bit. They also apply it to the other channel and pair it with an acknowledge, which shows whether it spills across channels or whether the acknowledge clears anything. A receive read is tried with and without remaining data, which separates a conditional clear from an unconditional one. Set and clear are driven together on the same bits to expose which one wins. Random cycles mix sparse events, frequent actions and mask writes, and a reference word tracked in the bench catches any wrong bit position or gating of the interrupt request.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NCH   = 2;
    localparam int NBITS = 8;
    localparam int CH_STRIDE = 4;

    // position of each event inside a channel's nibble
    localparam int OFS_TX  = 0;
    localparam int OFS_RX  = 1;
    localparam int OFS_BRK = 2;

    // shared bits
    localparam int POS_TMR = 3;
    localparam int POS_INP = 7;

    typedef logic [NBITS-1:0] stat_t;

    typedef struct packed {
        logic brk;
        logic rx;
        logic tx;
    } chan_vec_t;

    function automatic int chan_pos(input int ch, input int ofs);
        return ch * CH_STRIDE + ofs;
    endfunction
endpackage

// File: rtl/irq_chan_decode.sv
module irq_chan_decode (
    input  logic                 tx_evt,
    input  logic                 rx_evt,
    input  logic                 brk_evt,
    input  logic                 tx_wr,
    input  logic                 rx_rd,
    input  logic                 rx_more,
    input  logic                 brk_cmd,
    output irq_pkg::chan_vec_t   set_o,
    output irq_pkg::chan_vec_t   clr_o
);
    always_comb begin
        set_o.tx  = tx_evt;
        set_o.rx  = rx_evt;
        set_o.brk = brk_evt;
        clr_o.tx  = tx_wr;
        clr_o.rx  = rx_rd & ~rx_more;
        clr_o.brk = brk_cmd;
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_i) | set_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> q[i]);
        p_hold_r2: assert property (@(posedge clk) disable iff (rst)
            (!set_i[i] && !clr_i[i]) |=> (q[i] == $past(q[i])));
        p_clear_r12: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !q[i]);
    end
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] stat_i,
    output logic [W-1:0] mask_q,
    output logic         irq_n
);
    always_ff @(posedge clk) begin
        if (rst)     mask_q <= '0;
        else if (we) mask_q <= wdata;
    end

    assign irq_n = ~|(stat_i & mask_q);

    p_mask_load_r11: assert property (@(posedge clk) disable iff (rst)
        we |=> (mask_q == $past(wdata)));
    p_mask_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mask_q));
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] evt_tx_rdy,
    input  logic [1:0] evt_rx_rdy,
    input  logic [1:0] evt_brk_chg,
    input  logic       evt_tmr_rdy,
    input  logic       evt_in_chg,
    input  logic [1:0] acc_tx_write,
    input  logic [1:0] acc_rx_read,
    input  logic [1:0] acc_rx_more,
    input  logic [1:0] cmd_brk_ack,
    input  logic       cmd_tmr_stop,
    input  logic       acc_in_chg_read,
    input  logic       intack,
    input  logic       mask_we,
    input  logic [7:0] mask_wdata,
    output logic [7:0] stat,
    output logic [7:0] mask,
    output logic       irq_n
);
    import irq_pkg::*;

    stat_t set_v, clr_v;
    chan_vec_t ch_set [NCH];
    chan_vec_t ch_clr [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        irq_chan_decode i_dec (
            .tx_evt  (evt_tx_rdy[c]),
            .rx_evt  (evt_rx_rdy[c]),
            .brk_evt (evt_brk_chg[c]),
            .tx_wr   (acc_tx_write[c]),
            .rx_rd   (acc_rx_read[c]),
            .rx_more (acc_rx_more[c]),
            .brk_cmd (cmd_brk_ack[c]),
            .set_o   (ch_set[c]),
            .clr_o   (ch_clr[c])
        );
    end

    always_comb begin
        set_v = '0;
        clr_v = '0;
        for (int c = 0; c < NCH; c++) begin
            set_v[chan_pos(c, OFS_TX)]  = ch_set[c].tx;
            set_v[chan_pos(c, OFS_RX)]  = ch_set[c].rx;
            set_v[chan_pos(c, OFS_BRK)] = ch_set[c].brk;
            clr_v[chan_pos(c, OFS_TX)]  = ch_clr[c].tx;
            clr_v[chan_pos(c, OFS_RX)]  = ch_clr[c].rx;
            clr_v[chan_pos(c, OFS_BRK)] = ch_clr[c].brk;
        end
        set_v[POS_TMR] = evt_tmr_rdy;
        clr_v[POS_TMR] = cmd_tmr_stop;
        set_v[POS_INP] = evt_in_chg;
        clr_v[POS_INP] = acc_in_chg_read;
    end

    irq_status_reg #(.W(NBITS)) i_stat (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_v),
        .clr_i (clr_v),
        .q     (stat)
    );

    irq_mask_gate #(.W(NBITS)) i_mask (
        .clk    (clk),
        .rst    (rst),
        .we     (mask_we),
        .wdata  (mask_wdata),
        .stat_i (stat),
        .mask_q (mask),
        .irq_n  (irq_n)
    );

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (stat == '0 && mask == '0 && irq_n));
    // acknowledge alone never drops a bit
    p_ack_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (intack && clr_v == '0) |=> (($past(stat) & ~stat) == '0));
    p_rx_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_rx_read[0] && acc_rx_more[0] && stat[1]) |=> stat[1]);
    p_brk_only_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        (stat[2] && !cmd_brk_ack[0]) |=> stat[2]);
endmodule

// File: tb/test_irq_status_hub.sv
module test_irq_status_hub;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst = 1;
    logic [1:0] evt_tx_rdy, evt_rx_rdy, evt_brk_chg;
    logic       evt_tmr_rdy, evt_in_chg;
    logic [1:0] acc_tx_write, acc_rx_read, acc_rx_more, cmd_brk_ack;
    logic       cmd_tmr_stop, acc_in_chg_read, intack, mask_we;
    logic [7:0] mask_wdata;
    logic [7:0] stat, mask;
    logic       irq_n;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] exp_st = '0, exp_mk = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_hub i_irq_status_hub (.*);

    function automatic logic [7:0] set_vec();
        return {evt_in_chg, evt_brk_chg[1], evt_rx_rdy[1], evt_tx_rdy[1],
                evt_tmr_rdy, evt_brk_chg[0], evt_rx_rdy[0], evt_tx_rdy[0]};
    endfunction

    function automatic logic [7:0] clr_vec();
        return {acc_in_chg_read, cmd_brk_ack[1], acc_rx_read[1] & ~acc_rx_more[1],
                acc_tx_write[1], cmd_tmr_stop, cmd_brk_ack[0],
                acc_rx_read[0] & ~acc_rx_more[0], acc_tx_write[0]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        evt_tx_rdy = 0; evt_rx_rdy = 0; evt_brk_chg = 0; evt_tmr_rdy = 0; evt_in_chg = 0;
        acc_tx_write = 0; acc_rx_read = 0; acc_rx_more = 0; cmd_brk_ack = 0;
        cmd_tmr_stop = 0; acc_in_chg_read = 0; intack = 0; mask_we = 0; mask_wdata = 0;
    endtask

    // one clock with the inputs currently driven, then compare against the model
    task automatic run_cycle(input string tag);
        logic [7:0] nst, nmk;
        nst = (exp_st & ~clr_vec()) | set_vec();
        nmk = mask_we ? mask_wdata : exp_mk;
        @(negedge clk);
        exp_st = nst;
        exp_mk = nmk;
        check(stat == exp_st, tag, stat, exp_st);
        check(mask == exp_mk, "R11", mask, exp_mk);
        check(irq_n == ~|(exp_st & exp_mk), "R10", {7'd0, irq_n}, {7'd0, ~|(exp_st & exp_mk)});
        idle_inputs();
    endtask

    task automatic fill_all();
        evt_tx_rdy = 2'b11; evt_rx_rdy = 2'b11; evt_brk_chg = 2'b11;
        evt_tmr_rdy = 1; evt_in_chg = 1;
        run_cycle("R2");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(stat == 8'h00, "R1", stat, 8'h00);
        check(mask == 8'h00, "R1", mask, 8'h00);
        check(irq_n == 1'b1, "R1", {7'd0, irq_n}, 8'h01);
        rst = 0;

        // R2: single events land on their own positions
        for (int b = 0; b < 8; b++) begin
            case (b)
                0: evt_tx_rdy[0] = 1;  1: evt_rx_rdy[0] = 1;
                2: evt_brk_chg[0] = 1; 3: evt_tmr_rdy = 1;
                4: evt_tx_rdy[1] = 1;  5: evt_rx_rdy[1] = 1;
                6: evt_brk_chg[1] = 1; default: evt_in_chg = 1;
            endcase
            run_cycle("R2");
        end
        check(stat == 8'hFF, "R2", stat, 8'hFF);

        // R10: irq gated by mask
        check(irq_n == 1'b1, "R10", {7'd0, irq_n}, 8'h01);
        mask_we = 1; mask_wdata = 8'h40; run_cycle("R11");
        check(irq_n == 1'b0, "R10", {7'd0, irq_n}, 8'h00);

        // R8: acknowledge clears nothing
        intack = 1; run_cycle("R8");
        check(stat == 8'hFF, "R8", stat, 8'hFF);

        // R3 and R12: transmit write, channel 1 only
        acc_tx_write[1] = 1; run_cycle("R3");
        check(stat == 8'hEF, "R3", stat, 8'hEF);
        acc_tx_write[0] = 1; run_cycle("R3");
        check(stat == 8'hEE, "R12", stat, 8'hEE);

        // R4: read with data remaining keeps the bit, last read clears it
        acc_rx_read[0] = 1; acc_rx_more[0] = 1; run_cycle("R4");
        check(stat[1] == 1'b1, "R4", stat, 8'hEE);
        acc_rx_read[0] = 1; run_cycle("R4");
        check(stat == 8'hEC, "R4", stat, 8'hEC);

        // R5: other actions leave break bits, command clears own channel
        acc_in_chg_read = 1; cmd_tmr_stop = 1; acc_rx_read = 2'b11; intack = 1;
        run_cycle("R5");
        check(stat == 8'h44, "R5", stat, 8'h44);
        cmd_brk_ack[1] = 1; run_cycle("R5");
        check(stat == 8'h04, "R12", stat, 8'h04);
        check(irq_n == 1'b1, "R10", {7'd0, irq_n}, 8'h01);
        cmd_brk_ack[0] = 1; run_cycle("R5");

        // R6, R7
        fill_all();
        cmd_tmr_stop = 1; run_cycle("R6");
        check(stat == 8'hF7, "R6", stat, 8'hF7);
        acc_in_chg_read = 1; run_cycle("R7");
        check(stat == 8'h77, "R7", stat, 8'h77);

        // R9: set and clear together on every bit
        evt_tx_rdy = 2'b11; evt_rx_rdy = 2'b11; evt_brk_chg = 2'b11;
        evt_tmr_rdy = 1; evt_in_chg = 1;
        acc_tx_write = 2'b11; acc_rx_read = 2'b11; cmd_brk_ack = 2'b11;
        cmd_tmr_stop = 1; acc_in_chg_read = 1;
        run_cycle("R9");
        check(stat == 8'hFF, "R9", stat, 8'hFF);

        // R1: reset mid-run
        mask_we = 1; mask_wdata = 8'hFF; run_cycle("R11");
        rst = 1; @(negedge clk); rst = 0;
        exp_st = '0; exp_mk = '0;
        check(stat == 8'h00 && mask == 8'h00 && irq_n, "R1", stat, 8'h00);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            evt_tx_rdy  = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
            evt_rx_rdy  = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
            evt_brk_chg = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
            evt_tmr_rdy = ($urandom % 10 == 0);
            evt_in_chg  = ($urandom % 10 == 0);
            acc_tx_write = 2'($urandom) & 2'($urandom);
            acc_rx_read  = 2'($urandom);
            acc_rx_more  = 2'($urandom);
            cmd_brk_ack  = 2'($urandom) & 2'($urandom);
            cmd_tmr_stop = ($urandom % 4 == 0);
            acc_in_chg_read = ($urandom % 4 == 0);
            intack  = 1'($urandom);
            mask_we = ($urandom % 16 == 0);
            mask_wdata = 8'($urandom);
            run_cycle("R2");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule